// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits on the host side of a three-wire serial EEPROM link. It drives chip select, the shift clock and the serial data line toward the memory, and it samples the memory's serial output. A client hands it one command at a time on a valid/ready handshake: a command code, an address, a write word and a flag that tells it whether the memory is organised as bytes (x8) or as 16-bit words (x16). The controller builds the serial instruction, shifts it out, collects read data, and, after any programming command, deselects the memory for a minimum time and then reselects it to poll the ready/busy level until the memory reports completion or a time limit expires.

Each command ends with a one-cycle done pulse, a read word and an error flag. The shift clock rate comes from a divider parameter that counts system clocks per half period. A per-command flag makes the controller send a programming-enable instruction ahead of a programming command. The memory powers up with programming disabled, so a client can use this flag to avoid sending the enable itself.

Top module: `serial_eeprom_host`

## Requirements
- R1: Every instruction is shifted MSB first as a 1 start bit, a 2-bit opcode and an address field of 7 bits in x8 mode (`req_wide`=0) or 6 bits in x16 mode (`req_wide`=1). Command codes on `req_op`: 0 read (opcode 10), 1 write (01), 2 erase (11), 3 erase-all, 4 write-all, 5 programming-enable, 6 programming-disable (the last four use opcode 00).
- R2: For opcode-00 commands the two most significant address-field bits carry 11 for enable, 10 for erase-all, 01 for write-all and 00 for disable (and for the unused code 7), and the remaining field bits are 0.
- R3: For a read, the serial-output sample taken while the last address bit is clocked is the 0 dummy bit and is discarded. The next 8 (x8) or 16 (x16) samples form the read word MSB first. In x8 mode the word is returned in `rsp_rdata[7:0]` with the upper byte 0.
- R4: Write and write-all append the data word directly after the address field, MSB first: `req_wdata[7:0]` in x8 mode, `req_wdata[15:0]` in x16 mode.
- R5: The shift clock idles low whenever chip select is low, its period is 2*CLK_DIV system clocks, and the data line changes only while the shift clock is low. The memory's output is sampled at the end of each shift-clock high phase.
- R6: After every instruction, chip select stays low for at least CS_LOW_CLKS system clocks before it is raised again or done is signalled.
- R7: After write, erase, erase-all and write-all, chip select is raised again and the serial output is polled. Done follows once a 1 is seen, with `rsp_err`=0.
- R8: If the polled level stays 0 for POLL_LIMIT system clocks, the command ends with done and `rsp_err`=1. `rsp_err` is never high without done.
- R9: With `req_auto_en`=1, a programming command is preceded by a complete programming-enable instruction with its own chip-select low time. Read, enable and disable ignore the flag.
- R10: `req_ready` is high only while the controller is idle. `rsp_done` is a one-cycle pulse, and `req_ready` returns in the cycle after it.
- R11: Read, enable and disable raise chip select exactly once and do not poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Controller idle and able to accept a command |
| req_op | input | 3 | Command code (see R1) |
| req_wide | input | 1 | Organisation flag: 1 = x16, 0 = x8 |
| req_auto_en | input | 1 | Send programming-enable first for programming commands |
| req_addr | input | ADDR_X8 | Memory address (low ADDR_X8-1 bits used in x16) |
| req_wdata | input | DATA_W | Write data word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Ready/busy poll timed out (valid with done) |
| rsp_rdata | output | DATA_W | Read word, right-aligned |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data and ready/busy level from the memory |

## Verification
The bench builds the controller with CLK_DIV=4, CS_LOW_CLKS=6 and POLL_LIMIT=200. With these values a 26-bit instruction takes about two hundred cycles, the minimum-low window can be measured to the cycle, and a memory model held busy for 1000 cycles drives the timeout path. A behavioural memory model with both organisations captures every frame bit for comparison with frames computed independently, places the dummy bit ahead of read data, and models the power-up disabled state. The same model checks that disabled writes leave the contents untouched.

// File: rtl/sep_pkg.sv
// Shared types for the serial EEPROM host controller.
// Assumes command codes 0..6 as listed in the brief; 7 behaves as disable.
package sep_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_ERAL  = 3'd3,
        OP_WRAL  = 3'd4,
        OP_WEN   = 3'd5,
        OP_WDS   = 3'd6,
        OP_RSVD  = 3'd7
    } sep_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_GAP   = 3'd3,
        ST_POLL  = 3'd4,
        ST_TAIL  = 3'd5,
        ST_DONE  = 3'd6
    } sep_state_e;

    function automatic logic is_prog(sep_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERAL) || (op == OP_WRAL);
    endfunction

endpackage

// File: rtl/sep_tick.sv
// Half-period tick generator for the shift clock.
// Emits a one-cycle tick every DIV system clocks while enabled; the count
// restarts from zero whenever the enable is low.
module sep_tick #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    // Count system clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sep_frame.sv
// Instruction frame builder (combinational).
// Produces the serial frame left-aligned in FW bits plus the number of shift
// clocks to issue. Read frames include trailing zero bits that clock out the
// dummy and data bits; the last header bit's sample is the dummy.
module sep_frame
    import sep_pkg::*;
#(
    parameter int AX  = 7,
    parameter int DW  = 16,
    parameter int FW  = 3 + AX + DW,
    parameter int NBW = $clog2(FW + 1)
) (
    input  sep_op_e          op,
    input  logic             wide,
    input  logic [AX-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [FW-1:0]    frame,
    output logic [NBW-1:0]   nbits
);
    localparam int AW = AX - 1;
    localparam int DN = DW / 2;

    logic [1:0]    opc;
    logic [1:0]    ext;
    logic [AX-1:0] field;
    logic          has_data;
    logic          has_tail;
    logic [DW-1:0] wd;

    // Opcode and extended-command prefix per command.
    always_comb begin
        unique case (op)
            OP_READ:  opc = 2'b10;
            OP_WRITE: opc = 2'b01;
            OP_ERASE: opc = 2'b11;
            default:  opc = 2'b00;
        endcase
        unique case (op)
            OP_WEN:  ext = 2'b11;
            OP_ERAL: ext = 2'b10;
            OP_WRAL: ext = 2'b01;
            default: ext = 2'b00;
        endcase
    end

    // Address field, data word and frame assembly.
    always_comb begin
        has_data = (op == OP_WRITE) || (op == OP_WRAL);
        has_tail = has_data || (op == OP_READ);
        wd       = has_data ? wdata : '0;
        if (opc == 2'b00)  field = {ext, {(AX-2){1'b0}}};
        else if (wide)     field = {addr[AW-1:0], 1'b0};
        else               field = addr;
        if (wide) frame = {1'b1, opc, field[AX-1:1], wd, 1'b0};
        else      frame = {1'b1, opc, field, wd[DN-1:0], {DN{1'b0}}};
        nbits = NBW'(3) + (wide ? NBW'(AW) : NBW'(AX))
              + (has_tail ? (wide ? NBW'(DW) : NBW'(DN)) : NBW'(0));
    end
endmodule

// File: rtl/sep_shift.sv
// Bit serializer and deserializer for one chip-select frame.
// Each bit spends one tick with the shift clock low (data set up) and one with
// it high; the input is captured and the next bit presented as the clock falls.
module sep_shift #(
    parameter int FW  = 26,
    parameter int DW  = 16,
    parameter int NBW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [FW-1:0]  frame,
    input  logic [NBW-1:0] nbits,
    input  logic           tick,
    input  logic           so_in,
    output logic           active,
    output logic           sk,
    output logic           di,
    output logic           done,
    output logic [DW-1:0]  rx
);
    logic [FW-1:0]  sr;
    logic [NBW-1:0] left;
    logic           high;

    // Frame load, clock phase stepping and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0; left <= '0; high <= 1'b0; active <= 1'b0;
            sk <= 1'b0; di <= 1'b0; done <= 1'b0; rx <= '0;
        end else begin
            done <= 1'b0;
            if (load && !active) begin
                sr     <= frame;
                left   <= nbits;
                high   <= 1'b0;
                active <= 1'b1;
                sk     <= 1'b0;
                di     <= frame[FW-1];
            end else if (active && tick) begin
                if (!high) begin
                    sk   <= 1'b1;
                    high <= 1'b1;
                end else begin
                    sk   <= 1'b0;
                    high <= 1'b0;
                    rx   <= {rx[DW-2:0], so_in};
                    sr   <= sr << 1;
                    di   <= (left > NBW'(1)) ? sr[FW-2] : 1'b0;
                    left <= left - 1'b1;
                    if (left == NBW'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/serial_eeprom_host.sv
// Three-wire serial EEPROM host controller (top).
// Accepts one command at a time, optionally prefixes a programming enable,
// shifts the frame, enforces the chip-select low window after every frame,
// polls ready/busy after programming commands, and reports done/error/data.
// Assumes ee_do is asynchronous to clk; it passes through a two-flop sync.
module serial_eeprom_host
    import sep_pkg::*;
#(
    parameter int ADDR_X8     = 7,
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 25,
    parameter int CS_LOW_CLKS = 25,
    parameter int POLL_LIMIT  = 600000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic                req_wide,
    input  logic                req_auto_en,
    input  logic [ADDR_X8-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                ee_cs,
    output logic                ee_sk,
    output logic                ee_di,
    input  logic                ee_do
);
    localparam int FW     = 3 + ADDR_X8 + DATA_W;
    localparam int NBW    = $clog2(FW + 1);
    localparam int DN     = DATA_W / 2;
    localparam int SETTLE = CLK_DIV + 2;
    localparam int TMAX   = (POLL_LIMIT > CS_LOW_CLKS) ? POLL_LIMIT : CS_LOW_CLKS;
    localparam int TW     = $clog2(TMAX + SETTLE + 1);

    sep_state_e         state;
    sep_op_e            op_q;
    sep_op_e            op_cur;
    logic               wide_q;
    logic               pre_q;
    logic               err_q;
    logic [ADDR_X8-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [TW-1:0]      tmr;
    logic [1:0]         do_sync;
    logic               do_s;

    logic [FW-1:0]      frame;
    logic [NBW-1:0]     nbits;
    logic               sh_active, sh_done, tick;
    logic [DATA_W-1:0]  sh_rx;

    assign op_cur    = pre_q ? OP_WEN : op_q;
    assign do_s      = do_sync[1];
    assign req_ready = (state == ST_IDLE);
    assign rsp_done  = (state == ST_DONE);
    assign rsp_err   = rsp_done && err_q;
    assign rsp_rdata = rdata_q;

    sep_frame #(.AX(ADDR_X8), .DW(DATA_W), .FW(FW), .NBW(NBW)) u_frame (
        .op(op_cur), .wide(wide_q), .addr(addr_q), .wdata(wdata_q),
        .frame(frame), .nbits(nbits)
    );

    sep_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(sh_active), .tick(tick)
    );

    sep_shift #(.FW(FW), .DW(DATA_W), .NBW(NBW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(state == ST_LOAD), .frame(frame),
        .nbits(nbits), .tick(tick), .so_in(do_s), .active(sh_active),
        .sk(ee_sk), .di(ee_di), .done(sh_done), .rx(sh_rx)
    );

    // Synchronise the memory's serial output into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) do_sync <= 2'b00;
        else        do_sync <= {do_sync[0], ee_do};
    end

    // Command sequencer: accept, shift, low window, poll, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; op_q <= OP_READ; wide_q <= 1'b0; pre_q <= 1'b0;
            err_q <= 1'b0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
            tmr <= '0; ee_cs <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_q    <= sep_op_e'(req_op);
                    wide_q  <= req_wide;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    pre_q   <= req_auto_en && is_prog(sep_op_e'(req_op));
                    err_q   <= 1'b0;
                    rdata_q <= '0;
                    state   <= ST_LOAD;
                end
                ST_LOAD: begin
                    ee_cs <= 1'b1;
                    state <= ST_SHIFT;
                end
                ST_SHIFT: if (sh_done) begin
                    ee_cs <= 1'b0;
                    tmr   <= '0;
                    if (op_q == OP_READ && !pre_q)
                        rdata_q <= wide_q ? sh_rx : {{DN{1'b0}}, sh_rx[DN-1:0]};
                    state <= ST_GAP;
                end
                ST_GAP: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == TW'(CS_LOW_CLKS - 1)) begin
                        tmr <= '0;
                        if (pre_q) begin
                            pre_q <= 1'b0;
                            state <= ST_LOAD;
                        end else if (is_prog(op_q)) begin
                            ee_cs <= 1'b1;
                            state <= ST_POLL;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_POLL: begin
                    tmr <= tmr + 1'b1;
                    if (tmr >= TW'(SETTLE) && do_s) begin
                        ee_cs <= 1'b0;
                        tmr   <= '0;
                        state <= ST_TAIL;
                    end else if (tmr == TW'(POLL_LIMIT - 1)) begin
                        err_q <= 1'b1;
                        ee_cs <= 1'b0;
                        tmr   <= '0;
                        state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    tmr <= tmr + 1'b1;
                    if (tmr == TW'(CS_LOW_CLKS - 1)) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sep_checks.sv
// Protocol checker for serial_eeprom_host, attached by bind.
// Tracks chip-select low time with a saturating counter so the window
// check does not depend on a deep $past.
module sep_checks #(
    parameter int CS_LOW_CLKS = 25
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_done,
    input logic rsp_err,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    localparam int LW = $clog2(CS_LOW_CLKS + 1);

    logic [LW-1:0] low_cnt;

    // Count cycles with chip select low, saturating at the required window.
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_cnt <= LW'(CS_LOW_CLKS);
        else if (ee_cs)                      low_cnt <= '0;
        else if (low_cnt < LW'(CS_LOW_CLKS)) low_cnt <= low_cnt + 1'b1;
    end

    p_sk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    p_di_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    p_cs_low_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (low_cnt >= LW'(CS_LOW_CLKS)));

    p_err_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_ready_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(rsp_done));

    p_ready_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ee_cs);
endmodule

bind serial_eeprom_host sep_checks #(.CS_LOW_CLKS(CS_LOW_CLKS)) u_sep_checks (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/tb_serial_eeprom_host.sv
module tb_serial_eeprom_host;
    localparam int CLK_DIV = 4;
    localparam int CS_LOW  = 6;
    localparam int PLIM    = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = 3'd0;
    logic req_wide = 1'b0;
    logic req_auto_en = 1'b0;
    logic [6:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic ee_cs, ee_sk, ee_di, ee_do;

    always #2 clk = ~clk;

    serial_eeprom_host #(.ADDR_X8(7), .DATA_W(16), .CLK_DIV(CLK_DIV),
                         .CS_LOW_CLKS(CS_LOW), .POLL_LIMIT(PLIM)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_wide(req_wide), .req_auto_en(req_auto_en),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_tests = 0;
    int n_fail  = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- memory model ----------------
    logic        wide_mode = 1'b0;
    int          busy_len = 60;
    logic [7:0]  mem [128] = '{default: 8'hFF};
    logic        en = 1'b0;
    longint      busy_until = 0;
    logic [31:0] rxb = '0;
    int          nb = 0;
    logic        rd_on = 1'b0;
    logic        dq = 1'b0;
    logic [15:0] rd_sr = '0;
    int          rd_left = 0;
    logic [31:0] cap = '0, prev_cap = '0;
    int          cap_n = 0, prev_n = 0;

    assign ee_do = rd_on ? dq : (ee_cs ? (cyc >= busy_until) : 1'b0);

    always @(posedge ee_sk or negedge ee_cs) begin
        int a_w, d_w, adr;
        logic [31:0] f;
        a_w = wide_mode ? 6 : 7;
        d_w = wide_mode ? 16 : 8;
        if (ee_cs) begin
            if (rd_on) begin
                if (rd_left > 0) begin
                    dq = rd_sr[15]; rd_sr = rd_sr << 1; rd_left--;
                end
            end else begin
                rxb = {rxb[30:0], ee_di};
                nb++;
                if (nb == 3 + a_w && ((rxb >> a_w) & 32'd7) == 32'd6) begin
                    adr = int'(rxb & ((32'd1 << a_w) - 1));
                    rd_sr = wide_mode ? {mem[2*adr], mem[2*adr+1]} : {mem[adr], 8'h00};
                    rd_left = d_w; dq = 1'b0; rd_on = 1'b1;
                end
            end
        end else if (nb > 0) begin
            prev_cap = cap; prev_n = cap_n; cap = rxb; cap_n = nb;
            f = rxb << (32 - nb);
            adr = wide_mode ? int'(f[28:23]) : int'(f[28:22]);
            if (f[31] && nb == 3 + a_w + d_w && f[30:29] == 2'b01) begin
                if (en) begin
                    if (wide_mode) begin mem[2*adr] = f[22:15]; mem[2*adr+1] = f[14:7]; end
                    else mem[adr] = f[21:14];
                    busy_until = cyc + busy_len;
                end
            end else if (f[31] && nb == 3 + a_w + d_w && f[30:27] == 4'b0001) begin
                if (en) begin
                    for (int i = 0; i < 128; i++)
                        mem[i] = wide_mode ? ((i % 2 == 0) ? f[22:15] : f[14:7]) : f[21:14];
                    busy_until = cyc + busy_len;
                end
            end else if (f[31] && nb == 3 + a_w) begin
                if (f[30:29] == 2'b11 && en) begin
                    if (wide_mode) begin mem[2*adr] = 8'hFF; mem[2*adr+1] = 8'hFF; end
                    else mem[adr] = 8'hFF;
                    busy_until = cyc + busy_len;
                end else if (f[30:27] == 4'b0011) en = 1'b1;
                else if (f[30:27] == 4'b0000) en = 1'b0;
                else if (f[30:27] == 4'b0010 && en) begin
                    for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
                    busy_until = cyc + busy_len;
                end
            end
            nb = 0; rxb = '0; rd_on = 1'b0; dq = 1'b0;
        end
    end

    // ---------------- pin monitors ----------------
    int     cs_rises = 0;
    longint fall_cyc = 0;
    bit     seen_fall = 0;
    longint min_low = 1000;
    always @(posedge ee_cs or negedge ee_cs) begin
        if (ee_cs) begin
            cs_rises++;
            if (seen_fall && (cyc - fall_cyc) < min_low) min_low = cyc - fall_cyc;
        end else begin
            fall_cyc = cyc; seen_fall = 1;
        end
    end

    longint last_rise = 0;
    bit     have_rise = 0;
    longint min_per = 1000, max_per = 0;
    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) have_rise = 0;
        else begin
            if (have_rise) begin
                if (cyc - last_rise < min_per) min_per = cyc - last_rise;
                if (cyc - last_rise > max_per) max_per = cyc - last_rise;
            end
            last_rise = cyc; have_rise = 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [2:0] op, input logic w,
                                              input logic [6:0] a, input logic [15:0] d,
                                              output int n);
        int aw, dw;
        logic [31:0] v;
        logic [1:0] opc, ext;
        aw = w ? 6 : 7; dw = w ? 16 : 8;
        opc = (op == 0) ? 2'b10 : (op == 1) ? 2'b01 : (op == 2) ? 2'b11 : 2'b00;
        ext = (op == 5) ? 2'b11 : (op == 3) ? 2'b10 : (op == 4) ? 2'b01 : 2'b00;
        v = {29'd1, opc, 1'b0} >> 1;
        if (opc == 2'b00) v = (v << aw) | (32'(ext) << (aw - 2));
        else              v = (v << aw) | (32'(a) & ((32'd1 << aw) - 1));
        n = 3 + aw;
        if (op == 1 || op == 4) begin
            v = (v << dw) | (32'(d) & ((32'd1 << dw) - 1));
            n += dw;
        end
        return v;
    endfunction

    task automatic do_cmd(input logic [2:0] op, input logic w, input logic au,
                          input logic [6:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output logic e,
                          output int rises, output bit rdy_seen);
        int r0, cnt;
        wide_mode = w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = cs_rises;
        req_valid = 1'b1; req_op = op; req_wide = w; req_auto_en = au;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_seen = 0; cnt = 0;
        while (!rsp_done && cnt < 6000) begin
            if (req_ready) rdy_seen = 1;
            @(negedge clk); cnt++;
        end
        if (cnt >= 6000) chk(0, "R10", "watchdog waiting for done", 0, 1);
        rd = rsp_rdata; e = rsp_err; rises = cs_rises - r0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready in cycle after done", req_ready, 1);
    endtask

    // op, wide, auto, addr, wdata, expected rdata, expected err
    localparam int NV = 24;
    localparam logic [44:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 7'h05, 16'h0000, 16'h00FF, 1'b0},
        {3'd1, 1'b0, 1'b0, 7'h05, 16'h003C, 16'h0000, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h05, 16'h0000, 16'h00FF, 1'b0},
        {3'd5, 1'b1, 1'b0, 7'h00, 16'h0000, 16'h0000, 1'b0},
        {3'd1, 1'b0, 1'b0, 7'h05, 16'h003C, 16'h0000, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h05, 16'h0000, 16'h003C, 1'b0},
        {3'd1, 1'b1, 1'b0, 7'h2A, 16'hBEEF, 16'h0000, 1'b0},
        {3'd0, 1'b1, 1'b0, 7'h2A, 16'h0000, 16'hBEEF, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h54, 16'h0000, 16'h00BE, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h55, 16'h0000, 16'h00EF, 1'b0},
        {3'd2, 1'b1, 1'b0, 7'h2A, 16'h0000, 16'h0000, 1'b0},
        {3'd0, 1'b1, 1'b0, 7'h2A, 16'h0000, 16'hFFFF, 1'b0},
        {3'd4, 1'b0, 1'b0, 7'h00, 16'h005A, 16'h0000, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h7F, 16'h0000, 16'h005A, 1'b0},
        {3'd0, 1'b1, 1'b0, 7'h00, 16'h0000, 16'h5A5A, 1'b0},
        {3'd3, 1'b1, 1'b0, 7'h00, 16'h0000, 16'h0000, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h10, 16'h0000, 16'h00FF, 1'b0},
        {3'd6, 1'b0, 1'b0, 7'h00, 16'h0000, 16'h0000, 1'b0},
        {3'd1, 1'b1, 1'b0, 7'h03, 16'h1234, 16'h0000, 1'b0},
        {3'd0, 1'b1, 1'b0, 7'h03, 16'h0000, 16'hFFFF, 1'b0},
        {3'd1, 1'b1, 1'b1, 7'h03, 16'h1234, 16'h0000, 1'b0},
        {3'd0, 1'b1, 1'b0, 7'h03, 16'h0000, 16'h1234, 1'b0},
        {3'd0, 1'b0, 1'b0, 7'h07, 16'h0000, 16'h0034, 1'b0},
        {3'd6, 1'b1, 1'b0, 7'h00, 16'h0000, 16'h0000, 1'b0}
    };

    // Global watchdog: a hung run still reaches the summary line.
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 global watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic e;
        int rises, en_n, exp_n, exp_r;
        bit rdy_seen, prog;
        logic [31:0] ef;
        string rq;

        repeat (4) @(negedge clk);
        // Reset state (R10, R5)
        chk(req_ready == 1'b1, "R10", "ready during reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        chk(ee_cs == 1'b0, "R5", "cs idle low", ee_cs, 0);
        chk(ee_sk == 1'b0, "R5", "sk idle low", ee_sk, 0);
        chk(rsp_done == 1'b0, "R10", "done idle low", rsp_done, 0);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            do_cmd(v[44:42], v[41], v[40], v[39:33], v[32:17], rd, e, rises, rdy_seen);
            prog = (v[44:42] >= 3'd1) && (v[44:42] <= 3'd4);
            ef = exp_frame(v[44:42], v[41], v[39:33], v[32:17], exp_n);
            rq = (v[44:42] == 3'd0) ? "R1" : (v[44:42] == 3'd1 || v[44:42] == 3'd4) ? "R4"
               : (v[44:42] == 3'd2) ? "R1" : "R2";
            chk(cap_n == exp_n, rq, $sformatf("vec %0d frame length", i), cap_n, exp_n);
            chk(cap == ef, rq, $sformatf("vec %0d frame bits", i), cap, ef);
            if (v[44:42] == 3'd0)
                chk(rd == v[16:1], "R3", $sformatf("vec %0d read data", i), rd, v[16:1]);
            chk(e == v[0], "R7", $sformatf("vec %0d error flag", i), e, v[0]);
            exp_r = 1 + (prog ? 1 : 0) + ((prog && v[40]) ? 1 : 0);
            chk(rises == exp_r, prog ? "R7" : "R11", $sformatf("vec %0d cs raises", i), rises, exp_r);
            chk(!rdy_seen, "R10", $sformatf("vec %0d ready while busy", i), rdy_seen, 0);
            if (prog && v[40]) begin
                ef = exp_frame(3'd5, v[41], 7'h00, 16'h0000, en_n);
                chk(prev_cap == ef && prev_n == en_n, "R9", "auto enable frame", prev_cap, ef);
            end
        end

        // Auto flag ignored on a read (R9): one frame only, data intact.
        do_cmd(3'd0, 1'b1, 1'b1, 7'h03, 16'h0000, rd, e, rises, rdy_seen);
        chk(rises == 1, "R9", "auto flag on read cs raises", rises, 1);
        chk(rd == 16'h1234, "R9", "auto flag on read data", rd, 16'h1234);

        // Poll timeout (R8): memory held busy longer than the limit.
        do_cmd(3'd5, 1'b0, 1'b0, 7'h00, 16'h0000, rd, e, rises, rdy_seen);
        busy_len = 1000;
        do_cmd(3'd1, 1'b0, 1'b0, 7'h20, 16'h0011, rd, e, rises, rdy_seen);
        chk(e == 1'b1, "R8", "timeout error flag", e, 1);
        chk(rises == 2, "R8", "timeout cs raises", rises, 2);
        repeat (1100) @(negedge clk);
        busy_len = 60;
        do_cmd(3'd0, 1'b0, 1'b0, 7'h20, 16'h0000, rd, e, rises, rdy_seen);
        chk(e == 1'b0, "R8", "error clears on next command", e, 0);
        chk(rd == 16'h0011, "R3", "read after timed-out write", rd, 16'h0011);

        // Timing properties measured at the pins (R5, R6).
        chk(min_per == 2 * CLK_DIV, "R5", "min sk period", min_per, 2 * CLK_DIV);
        chk(max_per == 2 * CLK_DIV, "R5", "max sk period", max_per, 2 * CLK_DIV);
        chk(min_low >= CS_LOW, "R6", "min cs low cycles", min_low, CS_LOW);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule